// File: doc/BRIEF.md
# Linked Descriptor Fetch Engine

This block chains the transfers of several DMA channels without software help between them. Software writes a channel's descriptor pointer and then sets the channel's start bit. A command write carries a start value and an enable mask for each channel, and it changes only the start bits whose mask bit is set. The engine then reads a five-word descriptor from memory. It uses a plain word-read port and keeps at most one read in flight.

When all five words are in, the engine presents the descriptor for one cycle so the channel's registers can be loaded. Those fields are the control word, source, destination, transfer count, interrupt qualifiers and next pointer. In the same cycle it clears that channel's terminal-count status. It then waits for the transfer engine to report the channel done. If the descriptor's link flag was set and the start bit is still set, it follows the next pointer. Otherwise the chain ends.

A misaligned pointer or a read error ends the chain and raises a one-cycle error pulse for that channel. When several channels are waiting for a fetch, the lowest-numbered one is served first.

Top module: `sg_chain_walker`

## Requirements
- R1: A command write (`cmd_we`=1) sets `start_q[c]` to `cmd_start[c]` only for channels with `cmd_mask[c]`=1. Every other start bit keeps its value. Without a command write, no start bit ever rises.
- R2: Setting the start bit of an idle channel whose pointer has bits 1:0 equal to 0 causes five reads. They go to pointer+0, +4, +8, +12 and +16, in that order. At most one read is outstanding: `rd_req` is a one-cycle pulse, and the next pulse comes only after `rd_vld`.
- R3: One cycle after the fifth good response, `ld_vld` pulses with the following fields. `ld_ctrl`, `ld_src` and `ld_dst` come from words 0, 1 and 2. `ld_cnt` is word 3 bits 15:0. `ld_ie` is {word3[27] error, word3[28] end-of-transfer, word3[29] terminal-count}. `ld_next` is word 4.
- R4: `tc_clr` pulses for the loaded channel in the same cycle as `ld_vld`, once per loaded descriptor.
- R5: When `xfer_done[c]` arrives for a loaded channel whose descriptor has the link flag (word 3 bit 31) set, and `start_q[c]` is still 1, the engine fetches the next descriptor from word 4's address.
- R6: When `xfer_done[c]` arrives and the link flag is 0, `start_q[c]` is cleared the next cycle and no further read is issued for that channel.
- R7: Writing start=0 with mask=1 while a transfer runs does not abort it. When the done arrives, no further descriptor is fetched and no error is raised.
- R8: A response with `rd_err`=1 causes three things: `err_set[c]` pulses, `start_q[c]` clears, and the remaining reads of that descriptor are not issued. No load strobe follows.
- R9: Starting a channel whose pointer has bits 1:0 not equal to 0 pulses `err_set[c]` in the cycle after the write. It also clears `start_q[c]`, and no read is issued.
- R10: When several channels wait for a fetch, the lowest-numbered channel is fetched first.
- R11: After reset, `start_q`, `rd_req`, `ld_vld`, `tc_clr` and `err_set` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_start | input | NCH | Start/stop value for each channel |
| cmd_mask | input | NCH | Per-channel write enable for the start bits |
| ptr_we | input | 1 | Descriptor pointer write strobe |
| ptr_ch | input | CHW | Channel whose pointer is written |
| ptr_wdata | input | AW | New descriptor pointer |
| start_q | output | NCH | Current start bits |
| rd_req | output | 1 | Word read request (one-cycle pulse) |
| rd_addr | output | AW | Read byte address |
| rd_vld | input | 1 | Read response valid |
| rd_err | input | 1 | Read response error |
| rd_data | input | 32 | Read response word |
| ld_vld | output | 1 | Descriptor load strobe |
| ld_ch | output | CHW | Channel being loaded |
| ld_ctrl | output | 32 | Loaded control word |
| ld_src | output | AW | Loaded source address |
| ld_dst | output | AW | Loaded destination address |
| ld_cnt | output | CW | Loaded transfer count |
| ld_ie | output | 3 | {error, end-of-transfer, terminal-count} interrupt enables |
| ld_next | output | AW | Loaded next-descriptor address |
| tc_clr | output | NCH | Terminal-count status clear pulses |
| xfer_done | input | NCH | Transfer completion from the transfer engine |
| err_set | output | NCH | Error status set pulses |

## Verification
The assertions assume a well-behaved environment:
- A read response never arrives in the same cycle as its request.
- `xfer_done` is raised only for a channel that has been loaded.
- Software does not write a command in a cycle where a completion or a read response could clear a start bit. The start-bit checks are conditioned on that.

The stimulus keeps within these limits in several ways. Its memory model answers one to three cycles after each request. Its transfer model raises done only a few cycles after each observed load strobe. Commands are issued only while the channels they touch are idle, or, for the halt case, right after a load, well before the done can arrive.

// File: rtl/sg_chain_walker.sv
module sg_chain_walker #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_we,
  input  logic [NCH-1:0] cmd_start,
  input  logic [NCH-1:0] cmd_mask,
  input  logic           ptr_we,
  input  logic [CHW-1:0] ptr_ch,
  input  logic [AW-1:0]  ptr_wdata,
  output logic [NCH-1:0] start_q,
  output logic           rd_req,
  output logic [AW-1:0]  rd_addr,
  input  logic           rd_vld,
  input  logic           rd_err,
  input  logic [31:0]    rd_data,
  output logic           ld_vld,
  output logic [CHW-1:0] ld_ch,
  output logic [31:0]    ld_ctrl,
  output logic [AW-1:0]  ld_src,
  output logic [AW-1:0]  ld_dst,
  output logic [CW-1:0]  ld_cnt,
  output logic [2:0]     ld_ie,
  output logic [AW-1:0]  ld_next,
  output logic [NCH-1:0] tc_clr,
  input  logic [NCH-1:0] xfer_done,
  output logic [NCH-1:0] err_set
);
  localparam int LAST_W  = 4;
  localparam int LINK_B  = 31;
  localparam int TCIE_B  = 29;
  localparam int EOTIE_B = 28;
  localparam int ERRIE_B = 27;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fst_t;

  fst_t           fst;
  logic [CHW-1:0] fch, pick;
  logic [2:0]     widx;
  logic [31:0]    wbuf [4];
  logic [AW-1:0]  ptr [NCH];
  logic [NCH-1:0] pend, xfer, link;

  always_comb begin
    pick = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (pend[c]) pick = CHW'(c);
  end

  assign rd_req  = (fst == F_REQ);
  assign rd_addr = ptr[fch] + AW'({widx, 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fst     <= F_IDLE;
      fch     <= '0;
      widx    <= '0;
      start_q <= '0;
      pend    <= '0;
      xfer    <= '0;
      link    <= '0;
      ld_vld  <= 1'b0;
      ld_ch   <= '0;
      ld_ctrl <= '0;
      ld_src  <= '0;
      ld_dst  <= '0;
      ld_cnt  <= '0;
      ld_ie   <= '0;
      ld_next <= '0;
      tc_clr  <= '0;
      err_set <= '0;
      for (int c = 0; c < NCH; c++) ptr[c] <= '0;
      for (int i = 0; i < 4; i++) wbuf[i] <= '0;
    end else begin
      ld_vld  <= 1'b0;
      tc_clr  <= '0;
      err_set <= '0;
      if (ptr_we) ptr[ptr_ch] <= ptr_wdata;

      case (fst)
        F_IDLE: if (|pend) begin
          fch        <= pick;
          widx       <= '0;
          pend[pick] <= 1'b0;
          fst        <= F_REQ;
        end
        F_REQ: fst <= F_WAIT;
        default: if (rd_vld) begin
          if (rd_err) begin
            err_set[fch] <= 1'b1;
            start_q[fch] <= 1'b0;
            fst          <= F_IDLE;
          end else if (widx == 3'(LAST_W)) begin
            ld_vld      <= 1'b1;
            ld_ch       <= fch;
            ld_ctrl     <= wbuf[0];
            ld_src      <= wbuf[1][AW-1:0];
            ld_dst      <= wbuf[2][AW-1:0];
            ld_cnt      <= wbuf[3][CW-1:0];
            ld_ie       <= {wbuf[3][ERRIE_B], wbuf[3][EOTIE_B], wbuf[3][TCIE_B]};
            ld_next     <= rd_data[AW-1:0];
            tc_clr[fch] <= 1'b1;
            ptr[fch]    <= rd_data[AW-1:0];
            link[fch]   <= wbuf[3][LINK_B];
            xfer[fch]   <= 1'b1;
            fst         <= F_IDLE;
          end else begin
            wbuf[widx[1:0]] <= rd_data;
            widx            <= widx + 3'd1;
            fst             <= F_REQ;
          end
        end
      endcase

      for (int c = 0; c < NCH; c++) begin
        if (xfer_done[c] && xfer[c]) begin
          xfer[c] <= 1'b0;
          if (!link[c]) start_q[c] <= 1'b0;
          else if (start_q[c]) begin
            if (ptr[c][1:0] != 2'b00) begin
              err_set[c] <= 1'b1;
              start_q[c] <= 1'b0;
            end else pend[c] <= 1'b1;
          end
        end
        if (cmd_we && cmd_mask[c]) begin
          start_q[c] <= cmd_start[c];
          if (!cmd_start[c]) pend[c] <= 1'b0;
          else if (!start_q[c] && !xfer[c] && !pend[c] &&
                   !(fst != F_IDLE && fch == CHW'(c))) begin
            if (ptr[c][1:0] != 2'b00) begin
              err_set[c] <= 1'b1;
              start_q[c] <= 1'b0;
            end else pend[c] <= 1'b1;
          end
        end
      end
    end
  end

  // R1
  masked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && !(|xfer_done) && !rd_vld |=>
      ((start_q ^ $past(start_q)) & ~$past(cmd_mask)) == '0);

  // R1
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> (start_q & ~$past(start_q)) == '0);

  // R2
  word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[1:0] == 2'b00);

  // R2
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R3
  load_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld |-> $past(rd_vld && !rd_err));

  // R8
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld && rd_err |=> !rd_req && !ld_vld);

  // R6
  chain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((xfer_done & xfer & ~link) != '0) && !cmd_we |=>
      (start_q & $past(xfer_done & xfer & ~link)) == '0);
endmodule

// File: tb/sim_sg_chain_walker.sv
`timescale 1ns/1ps
module sim_sg_chain_walker;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [NCH-1:0] cmd_start = '0, cmd_mask = '0;
  logic ptr_we = 1'b0;
  logic [1:0] ptr_ch = '0;
  logic [31:0] ptr_wdata = '0;
  logic [NCH-1:0] start_q;
  logic rd_req;
  logic [31:0] rd_addr;
  logic rd_vld = 1'b0, rd_err = 1'b0;
  logic [31:0] rd_data = '0;
  logic ld_vld;
  logic [1:0] ld_ch;
  logic [31:0] ld_ctrl, ld_src, ld_dst, ld_next;
  logic [15:0] ld_cnt;
  logic [2:0] ld_ie;
  logic [NCH-1:0] tc_clr, err_set;
  logic [NCH-1:0] xfer_done = '0;

  sg_chain_walker u0 (.*);

  always #5 clk = ~clk;

  logic [31:0] mem [64];
  logic [31:0] exp_ptr [NCH];
  int nload [NCH], tcc [NCH], errc [NCH], tcnt [NCH];
  int nreads = 0, ncmp = 0, nerr = 0, rsp_cnt = 0, first_ch = -1;
  logic [31:0] rsp_a = '0;
  logic err_en = 1'b0;
  logic [7:0] err_addr = '0;
  bit done_flag = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_ie(input logic [31:0] w);
    return {w[27], w[28], w[29]};
  endfunction

  always @(negedge clk) begin
    xfer_done = '0;
    rd_vld = 1'b0;
    rd_err = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (tcnt[c] != 0) begin
        tcnt[c]--;
        if (tcnt[c] == 0) xfer_done[c] = 1'b1;
      end
    if (rsp_cnt != 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        rd_vld  = 1'b1;
        rd_data = mem[rsp_a[7:2]];
        rd_err  = err_en && (rsp_a[7:0] == err_addr);
      end
    end
    if (rd_req === 1'b1) begin
      rsp_a = rd_addr;
      rsp_cnt = 1 + int'($urandom % 3);
      nreads++;
    end
    if (ld_vld === 1'b1) begin
      automatic int c = int'(ld_ch);
      automatic int b = int'(exp_ptr[c][7:2]);
      if (first_ch < 0) first_ch = c;
      chk("R3 ctrl", ld_ctrl, mem[b]);
      chk("R3 src", ld_src, mem[b+1]);
      chk("R3 dst", ld_dst, mem[b+2]);
      chk("R3 cnt", {16'h0, ld_cnt}, {16'h0, mem[b+3][15:0]});
      chk("R3 ie", {29'h0, ld_ie}, {29'h0, exp_ie(mem[b+3])});
      chk("R3 next", ld_next, mem[b+4]);
      chk("R4 tc_clr", {28'h0, tc_clr}, 32'(1 << c));
      exp_ptr[c] = mem[b+4];
      nload[c]++;
      tcnt[c] = 3 + int'($urandom % 4);
    end
    for (int c = 0; c < NCH; c++) begin
      if (tc_clr[c] === 1'b1) tcc[c]++;
      if (err_set[c] === 1'b1) errc[c]++;
    end
  end

  task automatic clr_cnt();
    for (int c = 0; c < NCH; c++) begin
      nload[c] = 0; tcc[c] = 0; errc[c] = 0;
    end
    nreads = 0;
    first_ch = -1;
  endtask

  task automatic build_chain(input int base, input int n);
    for (int k = 0; k < n; k++) begin
      automatic int i = base + 5 * k;
      automatic logic lk = (k < n - 1);
      mem[i]   = $urandom;
      mem[i+1] = $urandom;
      mem[i+2] = $urandom;
      mem[i+3] = ($urandom & 32'h7FFF_FFFF) | {lk, 31'h0};
      mem[i+4] = lk ? 32'((i + 5) * 4) : ($urandom & 32'hFC);
    end
  endtask

  task automatic set_ptr(input int c, input logic [31:0] p);
    @(negedge clk);
    ptr_we = 1'b1; ptr_ch = 2'(c); ptr_wdata = p;
    exp_ptr[c] = p;
    @(negedge clk);
    ptr_we = 1'b0;
  endtask

  task automatic cmd(input logic [3:0] s, input logic [3:0] m);
    @(negedge clk);
    cmd_we = 1'b1; cmd_start = s; cmd_mask = m;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_idle(input logic [3:0] m);
    for (int k = 0; k < 3000 && (start_q & m) != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int c = 0; c < NCH; c++) begin
      exp_ptr[c] = '0; tcnt[c] = 0;
    end
    clr_cnt();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 start_q", {28'h0, start_q}, 32'h0);
    chk("R11 rd_req", {31'h0, rd_req}, 32'h0);
    chk("R11 ld_vld", {31'h0, ld_vld}, 32'h0);
    chk("R11 strobes", {24'h0, tc_clr, err_set}, 32'h0);

    // R1 masked-off start is ignored
    build_chain(0, 3);
    set_ptr(0, 32'h0);
    clr_cnt();
    cmd(4'b0001, 4'b0000);
    repeat (10) @(negedge clk);
    chk("R1 start ignored", {28'h0, start_q}, 32'h0);
    chk("R1 no reads", 32'(nreads), 32'h0);

    // R2 R5 R6 three-descriptor chain on channel 0
    cmd(4'b0001, 4'b0001);
    chk("R1 start set", {28'h0, start_q}, 32'h1);
    wait_idle(4'b0001);
    chk("R5 loads", 32'(nload[0]), 32'd3);
    chk("R2 reads", 32'(nreads), 32'd15);
    chk("R4 tc clears", 32'(tcc[0]), 32'd3);
    chk("R6 start cleared", {28'h0, start_q}, 32'h0);
    repeat (10) @(negedge clk);
    chk("R6 no extra reads", 32'(nreads), 32'd15);

    // R9 misaligned pointer
    clr_cnt();
    set_ptr(1, 32'h42);
    cmd(4'b0010, 4'b0010);
    repeat (5) @(negedge clk);
    chk("R9 err pulse", 32'(errc[1]), 32'd1);
    chk("R9 start cleared", {28'h0, start_q}, 32'h0);
    chk("R9 no reads", 32'(nreads), 32'd0);

    // R8 read error on third word
    clr_cnt();
    build_chain(20, 2);
    set_ptr(2, 32'd80);
    err_en = 1'b1; err_addr = 8'd88;
    cmd(4'b0100, 4'b0100);
    repeat (30) @(negedge clk);
    err_en = 1'b0;
    chk("R8 err pulse", 32'(errc[2]), 32'd1);
    chk("R8 start cleared", {28'h0, start_q}, 32'h0);
    chk("R8 reads stopped", 32'(nreads), 32'd3);
    chk("R8 no load", 32'(nload[2]), 32'd0);

    // R7 halt during transfer
    clr_cnt();
    build_chain(48, 3);
    set_ptr(3, 32'd192);
    cmd(4'b1000, 4'b1000);
    for (int k = 0; k < 200 && nload[3] == 0; k++) @(negedge clk);
    cmd_we = 1'b1; cmd_start = 4'b0000; cmd_mask = 4'b1000;
    @(negedge clk);
    cmd_we = 1'b0;
    repeat (40) @(negedge clk);
    chk("R7 one load", 32'(nload[3]), 32'd1);
    chk("R7 no next fetch", 32'(nreads), 32'd5);
    chk("R7 no error", 32'(errc[3]), 32'd0);
    chk("R7 start off", {28'h0, start_q}, 32'h0);

    // R10 lowest channel first
    clr_cnt();
    build_chain(40, 1);
    build_chain(45, 1);
    set_ptr(2, 32'd180);
    set_ptr(1, 32'd160);
    cmd(4'b0110, 4'b0110);
    wait_idle(4'b0110);
    chk("R10 first channel", 32'(first_ch), 32'd1);
    chk("R10 both loaded", 32'(nload[1] + nload[2]), 32'd2);

    // random concurrent chains
    for (int it = 0; it < 8; it++) begin
      automatic int a  = int'($urandom % 4);
      automatic int b  = (a + 1 + int'($urandom % 3)) % 4;
      automatic int la = 1 + int'($urandom % 3);
      automatic int lb = 1 + int'($urandom % 3);
      automatic logic [3:0] m = 4'((1 << a) | (1 << b));
      clr_cnt();
      build_chain(0, la);
      build_chain(20, lb);
      set_ptr(a, 32'd0);
      set_ptr(b, 32'd80);
      cmd(m, m);
      wait_idle(m);
      chk("R5 rand loads a", 32'(nload[a]), 32'(la));
      chk("R5 rand loads b", 32'(nload[b]), 32'(lb));
      chk("R2 rand reads", 32'(nreads), 32'(5 * (la + lb)));
      chk("R4 rand tc", 32'(tcc[a] + tcc[b]), 32'(la + lb));
      chk("R6 rand start off", {28'h0, start_q}, 32'h0);
    end
    finish_run();
  end
endmodule